// File: doc/BRIEF.md
# Three-Channel Programmable Sound Timer

This block generates square waves and pulse trains for sound effects from three programmable down-counter channels. A host writes it through an 8-bit, write-only timer port with a 3-bit offset. A second, 2-bit-offset effects port holds a 3-bit volume code per channel and a mute for channel 0. Each channel keeps a control byte, a 16-bit reload latch, a 16-bit counter and a one-bit output level.

A channel counts one of two sources. The first is a common enable tick. The second is an external noise tick. A channel can count as one 16-bit counter whose output toggles on each underflow. It can also count as two cascaded 8-bit counters, where the high byte decides when the output is high. The last channel has an optional divide-by-8 prescaler. The block sums the active channels' scaled amplitudes into one unsigned mix word.

Top module: `sfx_timer_trio`

## Requirements
- R1: After a synchronous active-low reset, every control byte, reload latch, counter, output level, volume, the mute bit and the shared high-byte staging register are zero, so `chan_level` = 0 and `mix_out` = 0.
- R2: A timer write at offset 1 always sets channel 1's control byte. A write at offset 0 sets channel 0's control byte when channel 1's control bit 0 is 1, and channel 2's control byte when that bit is 0.
- R3: Timer writes at offsets 2, 4 and 6 load one shared high-byte staging register. A write at offset 3, 5 or 7 sets the reload latch of channel (offset-3)/2 to {staging, data}. When that channel's control bit 4 is 0, its counter takes the same value on that edge. This load replaces any count step on that edge. When bit 4 is 1, the counter is left alone.
- R4: With control bit 2 = 0 (16-bit mode), each count step decrements the counter. A step at 0 instead reloads the counter from the latch and inverts the output level.
- R5: With control bit 2 = 1 (dual 8-bit mode), a step decrements the low byte. A step with the low byte at 0 reloads the low byte from the latch and decrements the high byte, and the output goes high when the high byte becomes 0. A step with both bytes at 0 reloads all 16 bits and drives the output low.
- R6: Control bit 1 = 1 selects `tick_en` as the channel's clock. Bit 1 = 0 selects `noise_tick`.
- R7: A channel whose control bit 7 is 0 does not count, and its `chan_level` bit and its mix contribution are 0.
- R8: When channel 2's control bit 0 is 1, only every eighth clock from its selected source makes a count step. The 3-bit prescale remainder is kept across gaps in the clock.
- R9: While channel 0's control bit 0 is 1, no channel counts and no prescaler advances.
- R10: Effects writes at offsets 1, 2 and 3 set the volume code (data bits 2:0) of channels 0, 1 and 2. `mix_out` is the sum of code x VOL_STEP over the channels whose `chan_level` bit is 1.
- R11: Bit 1 of an effects write at offset 0 is a mute for channel 0. While it is 1, channel 0's `chan_level` bit and contribution are 0.
- R12: Register writes and count steps take effect at the clock edge on which they are presented. `chan_level` and `mix_out` show the result after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_we | input | 1 | Timer port write strobe |
| tmr_addr | input | 3 | Timer port offset |
| tmr_wdata | input | 8 | Timer port write data |
| fx_we | input | 1 | Effects port write strobe |
| fx_addr | input | 2 | Effects port offset |
| fx_wdata | input | 8 | Effects port write data |
| tick_en | input | 1 | Common enable clock, one step per high cycle |
| noise_tick | input | 1 | External noise clock, one step per high cycle |
| chan_level | output | 3 | Gated output level per channel |
| mix_out | output | MIX_W | Unsigned sum of active channel amplitudes |

## Verification
Every result is due one clock edge after its stimulus. A register write, a tick or a noise pulse presented before edge N changes `chan_level` and `mix_out` just after edge N, since both outputs are combinational from state registers. The bench presents all inputs at the falling edge. It advances its reference model once for those inputs, then compares both outputs at the next falling edge, so each comparison sees exactly one edge of effect. Edges where a counter load and a count step coincide are handled the same way: the model lets the load win, as R3 requires.

// File: rtl/sfx_tmr_pkg.sv
// Package: shared widths and control-bit positions for the sound timer.
// Assumes an 8-bit host data path and a 16-bit counter made of two bytes.
package sfx_tmr_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int VOL_W  = 3;
    localparam int N_CH   = 3;
    localparam int VOL_MAX = (1 << VOL_W) - 1;

    // Control byte bit positions (bit 0 meaning depends on channel)
    localparam int CB_B0     = 0;  // ch0: hold all, ch1: route, ch2: prescale
    localparam int CB_CLKSEL = 1;  // 1 = enable tick, 0 = noise tick
    localparam int CB_DUAL   = 2;  // 1 = dual 8-bit mode
    localparam int CB_DEFER  = 4;  // 1 = do not load counter on LSB write
    localparam int CB_ENABLE = 7;  // channel active

    typedef logic [DATA_W-1:0] ctrl_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/sfx_regs.sv
// Module: sfx_regs
// Decodes the timer and effects write ports into control bytes, reload
// latches, the shared high-byte staging register, volumes and mute.
// Assumes at most one write per port per cycle; there is no read path.
module sfx_regs
    import sfx_tmr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tmr_we,
    input  logic [2:0]                  tmr_addr,
    input  logic [DATA_W-1:0]           tmr_wdata,
    input  logic                        fx_we,
    input  logic [1:0]                  fx_addr,
    input  logic [DATA_W-1:0]           fx_wdata,
    output logic [N_CH-1:0][DATA_W-1:0] ctrl_q,
    output logic [N_CH-1:0][CNT_W-1:0]  reload_q,
    output logic [DATA_W-1:0]           msb_q,
    output logic [N_CH-1:0][VOL_W-1:0]  vol_q,
    output logic                        mute_q,
    output logic [N_CH-1:0]             lsb_wr,
    output logic [CNT_W-1:0]            lsb_val
);
    logic unused_fx;
    assign unused_fx = ^{fx_wdata[DATA_W-1:VOL_W]};

    // Combined reload value presented with an LSB write
    assign lsb_val = {msb_q, tmr_wdata};

    // One LSB-write strobe per channel, offsets 3, 5 and 7
    genvar gc;
    generate
        for (gc = 0; gc < N_CH; gc++) begin : g_lsb
            assign lsb_wr[gc] = tmr_we && (tmr_addr == 3'(2 * gc + 3));
        end
    endgenerate

    // Timer port register decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            msb_q    <= '0;
        end else if (tmr_we) begin
            case (tmr_addr)
                3'd0: begin
                    if (ctrl_q[1][CB_B0]) ctrl_q[0] <= tmr_wdata;
                    else                  ctrl_q[2] <= tmr_wdata;
                end
                3'd1:               ctrl_q[1] <= tmr_wdata;
                3'd2, 3'd4, 3'd6:   msb_q     <= tmr_wdata;
                default:            reload_q[tmr_addr[2:1] - 2'd1] <= lsb_val;
            endcase
        end
    end

    // Effects port decode: mute at offset 0, volumes at offsets 1..3
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q  <= '0;
            mute_q <= 1'b0;
        end else if (fx_we) begin
            if (fx_addr == 2'd0) mute_q <= fx_wdata[1];
            else                 vol_q[fx_addr - 2'd1] <= fx_wdata[VOL_W-1:0];
        end
    end
endmodule

// File: rtl/sfx_chan.sv
// Module: sfx_chan
// One down-counter channel: clock select, optional divide-by-8 prescaler,
// 16-bit toggle mode and dual 8-bit mode. A counter load on an LSB write
// replaces any count step on the same edge.
module sfx_chan
    import sfx_tmr_pkg::*;
#(
    parameter bit HAS_PRE = 1'b0,
    parameter int PRE_W   = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [CNT_W-1:0]  reload,
    input  logic              lsb_wr,
    input  logic [CNT_W-1:0]  lsb_val,
    input  logic              hold,
    input  logic              tick_en,
    input  logic              noise_tick,
    output logic              out_q,
    output logic [CNT_W-1:0]  cnt_q
);
    localparam int HB = CNT_W / 2;

    logic src, run, step;
    logic unused_cb;
    assign unused_cb = ^{ctrl[6:5], ctrl[3]};

    // Selected clock source and the run qualifier
    assign src = ctrl[CB_CLKSEL] ? tick_en : noise_tick;
    assign run = src && ctrl[CB_ENABLE] && !hold;

    generate
        if (HAS_PRE) begin : g_pre
            logic [PRE_W-1:0] pre_q;
            // Prescale remainder, advances only on qualified clocks
            always_ff @(posedge clk) begin
                if (!rst_n)                  pre_q <= '0;
                else if (run && ctrl[CB_B0]) pre_q <= pre_q + 1'b1;
            end
            assign step = ctrl[CB_B0] ? (run && (&pre_q)) : run;
        end else begin : g_nopre
            logic unused_b0;
            assign unused_b0 = ctrl[CB_B0];
            assign step = run;
        end
    endgenerate

    // Counter and output level update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (lsb_wr && !ctrl[CB_DEFER]) begin
            cnt_q <= lsb_val;
        end else if (step) begin
            if (!ctrl[CB_DUAL]) begin
                if (cnt_q == '0) begin
                    cnt_q <= reload;
                    out_q <= ~out_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (cnt_q[HB-1:0] != '0) begin
                cnt_q[HB-1:0] <= cnt_q[HB-1:0] - 1'b1;
            end else if (cnt_q[CNT_W-1:HB] == '0) begin
                cnt_q <= reload;
                out_q <= 1'b0;
            end else begin
                cnt_q <= {cnt_q[CNT_W-1:HB] - 1'b1, reload[HB-1:0]};
                if (cnt_q[CNT_W-1:HB] == HB'(1)) out_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfx_mix.sv
// Module: sfx_mix
// Gates each channel level by enable and mute, scales by volume code and
// sums into an unsigned mix word. Purely combinational.
module sfx_mix
    import sfx_tmr_pkg::*;
#(
    parameter int VOL_STEP = 16,
    parameter int MIX_W    = 9
)(
    input  logic [N_CH-1:0]             lvl_raw,
    input  logic [N_CH-1:0]             ch_en,
    input  logic                        mute0,
    input  logic [N_CH-1:0][VOL_W-1:0]  vol,
    output logic [N_CH-1:0]             lvl,
    output logic [MIX_W-1:0]            mix
);
    // Gated level per channel
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            lvl[c] = lvl_raw[c] && ch_en[c] && !(c == 0 && mute0);
        end
    end

    // Weighted sum of the active channels
    always_comb begin
        mix = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (lvl[c]) mix = mix + MIX_W'(vol[c]) * MIX_W'(VOL_STEP);
        end
    end
endmodule

// File: rtl/sfx_timer_trio.sv
// Module: sfx_timer_trio (top)
// Three programmable sound timer channels behind a write-only register
// port, plus an effects port for volume and mute. Channel 2 carries the
// prescaler. Assumes tick inputs are single-cycle qualified pulses.
module sfx_timer_trio
    import sfx_tmr_pkg::*;
#(
    parameter int VOL_STEP = 16,
    parameter int PRE_W    = 3,
    parameter int MIX_W    = $clog2(3 * 7 * VOL_STEP + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_we,
    input  logic [2:0]       tmr_addr,
    input  logic [7:0]       tmr_wdata,
    input  logic             fx_we,
    input  logic [1:0]       fx_addr,
    input  logic [7:0]       fx_wdata,
    input  logic             tick_en,
    input  logic             noise_tick,
    output logic [2:0]       chan_level,
    output logic [MIX_W-1:0] mix_out
);
    logic [N_CH-1:0][DATA_W-1:0] ctrl_q;
    logic [N_CH-1:0][CNT_W-1:0]  reload_q;
    logic [N_CH-1:0][CNT_W-1:0]  cnt_q;
    logic [N_CH-1:0][VOL_W-1:0]  vol_q;
    logic [DATA_W-1:0]           msb_q;
    logic                        mute_q;
    logic [N_CH-1:0]             lsb_wr;
    logic [CNT_W-1:0]            lsb_val;
    logic [N_CH-1:0]             out_q;
    logic [N_CH-1:0]             ch_en;

    // Register decode for both host ports
    sfx_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .tmr_we(tmr_we), .tmr_addr(tmr_addr), .tmr_wdata(tmr_wdata),
        .fx_we(fx_we), .fx_addr(fx_addr), .fx_wdata(fx_wdata),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .msb_q(msb_q),
        .vol_q(vol_q), .mute_q(mute_q), .lsb_wr(lsb_wr), .lsb_val(lsb_val)
    );

    // Channel array; only the last channel has a prescaler
    genvar gc;
    generate
        for (gc = 0; gc < N_CH; gc++) begin : g_ch
            assign ch_en[gc] = ctrl_q[gc][CB_ENABLE];
            sfx_chan #(.HAS_PRE(gc == N_CH - 1), .PRE_W(PRE_W)) u_chan (
                .clk(clk), .rst_n(rst_n),
                .ctrl(ctrl_q[gc]), .reload(reload_q[gc]),
                .lsb_wr(lsb_wr[gc]), .lsb_val(lsb_val),
                .hold(ctrl_q[0][CB_B0]),
                .tick_en(tick_en), .noise_tick(noise_tick),
                .out_q(out_q[gc]), .cnt_q(cnt_q[gc])
            );
        end
    endgenerate

    // Output gating and mixing
    sfx_mix #(.VOL_STEP(VOL_STEP), .MIX_W(MIX_W)) u_mix (
        .lvl_raw(out_q), .ch_en(ch_en), .mute0(mute_q), .vol(vol_q),
        .lvl(chan_level), .mix(mix_out)
    );
endmodule

// File: rtl/sfx_timer_trio_chk.sv
// Module: sfx_timer_trio_chk
// Property checker attached to every sfx_timer_trio instance by bind.
module sfx_timer_trio_chk #(
    parameter int VOL_STEP = 16,
    parameter int MIX_W    = 9
)(
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_we,
    input logic [2:0]       tmr_addr,
    input logic [7:0]       tmr_wdata,
    input logic [2:0][7:0]  ctrl_q,
    input logic [2:0][15:0] cnt_q,
    input logic [2:0]       out_q,
    input logic [7:0]       msb_q,
    input logic             mute_q,
    input logic [2:0]       chan_level,
    input logic [MIX_W-1:0] mix_out
);
    a_r2_route_to_ch2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_we && tmr_addr == 3'd0 && !ctrl_q[1][0]) |=> $stable(ctrl_q[0]));

    a_r3_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_we && tmr_addr == 3'd3 && !ctrl_q[0][4])
        |=> cnt_q[0] == {$past(msb_q), $past(tmr_wdata)});

    a_r5_high_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[1][2]) && $rose(out_q[1])) |-> cnt_q[1][15:8] == 8'd0);

    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0][0] |=> $stable(out_q));

    a_r11_mute: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q |-> !chan_level[0]);

    a_r10_mix_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mix_out <= MIX_W'(3 * 7 * VOL_STEP));

    genvar gc;
    generate
        for (gc = 0; gc < 3; gc++) begin : g_en
            a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_q[gc][7] |-> !chan_level[gc]);
        end
    endgenerate
endmodule

bind sfx_timer_trio sfx_timer_trio_chk #(.VOL_STEP(VOL_STEP), .MIX_W(MIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_we(tmr_we), .tmr_addr(tmr_addr),
    .tmr_wdata(tmr_wdata), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .out_q(out_q),
    .msb_q(msb_q), .mute_q(mute_q), .chan_level(chan_level), .mix_out(mix_out)
);

// File: tb/sfx_timer_trio_tb.sv
`timescale 1ns/1ps
module sfx_timer_trio_tb;
    localparam int VOL_STEP = 16;
    localparam int MIX_W    = $clog2(3 * 7 * VOL_STEP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmr_we = 1'b0;
    logic [2:0] tmr_addr = '0;
    logic [7:0] tmr_wdata = '0;
    logic fx_we = 1'b0;
    logic [1:0] fx_addr = '0;
    logic [7:0] fx_wdata = '0;
    logic tick_en = 1'b0;
    logic noise_tick = 1'b0;
    logic [2:0] chan_level;
    logic [MIX_W-1:0] mix_out;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sfx_timer_trio #(.VOL_STEP(VOL_STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_we(tmr_we), .tmr_addr(tmr_addr),
        .tmr_wdata(tmr_wdata), .fx_we(fx_we), .fx_addr(fx_addr),
        .fx_wdata(fx_wdata), .tick_en(tick_en), .noise_tick(noise_tick),
        .chan_level(chan_level), .mix_out(mix_out)
    );

    // Reference model state, built from the requirements
    logic [7:0]  m_ctrl [3];
    logic [15:0] m_rel  [3];
    logic [15:0] m_cnt  [3];
    logic        m_out  [3];
    logic [2:0]  m_vol  [3];
    logic [7:0]  m_msb;
    logic        m_mute;
    logic [2:0]  m_pre;

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_ctrl[c] = '0; m_rel[c] = '0; m_cnt[c] = '0;
            m_out[c] = 1'b0; m_vol[c] = '0;
        end
        m_msb = '0; m_mute = 1'b0; m_pre = '0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [7:0] d,
                              input logic fwe, input logic [1:0] fa, input logic [7:0] fd,
                              input logic te, input logic nt);
        logic [7:0]  oc [3];
        logic [15:0] orl [3];
        logic [7:0]  omsb;
        logic [2:0]  opre;
        for (int c = 0; c < 3; c++) begin oc[c] = m_ctrl[c]; orl[c] = m_rel[c]; end
        omsb = m_msb; opre = m_pre;
        for (int c = 0; c < 3; c++) begin
            logic src, run, stp;
            src = oc[c][1] ? te : nt;                 // R6
            run = src && oc[c][7] && !oc[0][0];       // R7, R9
            stp = run;
            if (c == 2 && oc[2][0]) begin             // R8
                stp = run && (opre == 3'd7);
                if (run) m_pre = opre + 3'd1;
            end
            if (we && a == 3'(2 * c + 3) && !oc[c][4]) begin
                m_cnt[c] = {omsb, d};                 // R3
            end else if (stp) begin
                if (!oc[c][2]) begin                  // R4
                    if (m_cnt[c] == 16'd0) begin m_cnt[c] = orl[c]; m_out[c] = !m_out[c]; end
                    else m_cnt[c] = m_cnt[c] - 16'd1;
                end else if (m_cnt[c][7:0] != 8'd0) begin  // R5
                    m_cnt[c][7:0] = m_cnt[c][7:0] - 8'd1;
                end else if (m_cnt[c][15:8] == 8'd0) begin
                    m_cnt[c] = orl[c]; m_out[c] = 1'b0;
                end else begin
                    m_cnt[c][15:8] = m_cnt[c][15:8] - 8'd1;
                    m_cnt[c][7:0]  = orl[c][7:0];
                    if (m_cnt[c][15:8] == 8'd0) m_out[c] = 1'b1;
                end
            end
        end
        if (we) begin
            case (a)
                3'd0: if (oc[1][0]) m_ctrl[0] = d; else m_ctrl[2] = d;  // R2
                3'd1: m_ctrl[1] = d;
                3'd2, 3'd4, 3'd6: m_msb = d;
                default: m_rel[(a - 3'd3) >> 1] = {omsb, d};
            endcase
        end
        if (fwe) begin
            if (fa == 2'd0) m_mute = fd[1];                 // R11
            else m_vol[fa - 2'd1] = fd[2:0];                // R10
        end
    endtask

    function automatic logic [2:0] exp_level();
        logic [2:0] l;
        for (int c = 0; c < 3; c++)
            l[c] = m_out[c] && m_ctrl[c][7] && !(c == 0 && m_mute);
        return l;
    endfunction

    function automatic int exp_mix();
        int s = 0;
        logic [2:0] l = exp_level();
        for (int c = 0; c < 3; c++) if (l[c]) s += int'(m_vol[c]) * VOL_STEP;
        return s;
    endfunction

    task automatic compare();
        n_chk++;
        if (chan_level !== exp_level() || int'(mix_out) != exp_mix()) begin
            n_bad++;
            $display("FAIL %s: level=%b mix=%0d expected level=%b mix=%0d (R12 timing)",
                     cur_req, chan_level, mix_out, exp_level(), exp_mix());
        end
    endtask

    // One clock: drive at the falling edge, model the edge, compare after it
    task automatic cycle(input logic we, input logic [2:0] a, input logic [7:0] d,
                         input logic fwe, input logic [1:0] fa, input logic [7:0] fd,
                         input logic te, input logic nt);
        tmr_we = we; tmr_addr = a; tmr_wdata = d;
        fx_we = fwe; fx_addr = fa; fx_wdata = fd;
        tick_en = te; noise_tick = nt;
        model_step(we, a, d, fwe, fa, fd, te, nt);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic twr(input logic [2:0] a, input logic [7:0] d);
        cycle(1'b1, a, d, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0);
    endtask

    task automatic fwr(input logic [1:0] a, input logic [7:0] d);
        cycle(1'b0, 3'd0, 8'd0, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n, input logic te, input logic nt);
        for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 8'd0, te, nt);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();
        n_chk++;
        if (mix_out != '0) begin
            n_bad++;
            $display("FAIL R1: mix=%0d expected 0", mix_out);
        end

        // Volumes and channel setup
        cur_req = "R10";
        fwr(2'd1, 8'hF7); fwr(2'd2, 8'd3); fwr(2'd3, 8'd5);
        cur_req = "R2";
        twr(3'd1, 8'h00); twr(3'd0, 8'h82);   // goes to channel 2
        twr(3'd1, 8'h01); twr(3'd0, 8'h82);   // now channel 0
        cur_req = "R4";
        twr(3'd2, 8'h00); twr(3'd3, 8'h02);
        ticks(14, 1'b1, 1'b0);
        cur_req = "R5";
        twr(3'd1, 8'h87);
        twr(3'd4, 8'h02); twr(3'd5, 8'h01);
        ticks(24, 1'b1, 1'b0);
        cur_req = "R3";
        twr(3'd0, 8'h92);                     // defer load on ch0
        twr(3'd6, 8'h00); twr(3'd3, 8'h05);
        ticks(6, 1'b1, 1'b0);
        twr(3'd0, 8'h82); twr(3'd3, 8'h01);
        ticks(6, 1'b1, 1'b0);
        cur_req = "R8";
        twr(3'd1, 8'h86); twr(3'd0, 8'h83);   // ch2 prescaled
        twr(3'd7, 8'h00);
        for (int b = 0; b < 6; b++) begin
            ticks(5, 1'b1, 1'b0);
            ticks(3, 1'b0, 1'b0);
        end
        cur_req = "R6";
        twr(3'd0, 8'h80);                     // ch2 on noise
        ticks(10, 1'b1, 1'b0);
        ticks(10, 1'b0, 1'b1);
        cur_req = "R9";
        twr(3'd1, 8'h87); twr(3'd0, 8'h83);   // ch0 hold
        ticks(12, 1'b1, 1'b1);
        twr(3'd0, 8'h82);
        ticks(8, 1'b1, 1'b1);
        cur_req = "R11";
        fwr(2'd0, 8'h02);
        ticks(8, 1'b1, 1'b0);
        fwr(2'd0, 8'h00);
        ticks(8, 1'b1, 1'b0);
        cur_req = "R7";
        twr(3'd1, 8'h07);
        ticks(8, 1'b1, 1'b0);

        // Constrained random traffic
        cur_req = "R12";
        for (int i = 0; i < 4000; i++) begin
            logic we, fwe;
            logic [2:0] a;
            logic [7:0] d;
            we  = ($urandom % 6) == 0;
            fwe = ($urandom % 16) == 0;
            a   = 3'($urandom);
            d   = 8'($urandom);
            if (a == 3'd2 || a == 3'd4 || a == 3'd6) d = 8'($urandom % 3);
            if (a == 3'd0 || a == 3'd1) d = d | 8'h80;
            if (a == 3'd0 && ($urandom % 4) != 0) d[0] = 1'b0;
            if (a == 3'd3 || a == 3'd5 || a == 3'd7) d = 8'($urandom % 6);
            cycle(we, a, d, fwe, 2'($urandom), 8'($urandom),
                  ($urandom % 2) == 0, ($urandom % 4) == 0);
        end
        summary();
    end
endmodule